// File: doc/BRIEF.md
# Wide Data Path Negotiation Responder

This block sits on the target side of a PCI-style parallel bus. At the address phase of each transaction it decides whether this agent claims the access, and whether the access runs over the full 64-bit data path or falls back to 32 bits. Only the address phase is sampled: the falling edge of the active-low frame line, the wide-request line, the command code and the address. The block then drives the active-low device-select and wide-acknowledge lines. The acknowledge keeps exactly the same assertion and release timing as device-select.

The grant is latched for the whole transaction. A wide grant needs all of these: a memory command, a wide request sampled in that same address phase, a quadword-aligned start address, and a decoded region that is configured as wide-capable. In every other case the transaction completes at 32 bits. The target-ready and stop lines come from the surrounding target logic. The block watches them to report completed data phases to the internal data path (low lanes always, upper lanes only in wide mode), to find the end of the transaction and to classify how it ended.

Top module: `wide_neg_resp`

## Requirements
- R1: After a synchronous reset `devsel_n` and `ack64_n` are high, and `beat_lo`, `beat_hi` and `xact_end` are low.
- R2: The address phase is the first clock with `frame_n` low while the block is idle. `devsel_n` goes low at the edge that samples it when `claim_req` is high and `ad` lies in [BASE_ADDR, BASE_ADDR+REGION_BYTES). Otherwise `devsel_n` stays high for the whole transaction.
- R3: `ack64_n` goes low only in the same cycle as `devsel_n`, and only when `req64_n` was low in that address phase.
- R4: The wide grant is refused for every command except the memory codes 0110, 0111, 1100, 1110 and 1111. I/O (0010, 0011), configuration (1010, 1011), interrupt acknowledge (0000) and special cycle (0001) always complete at 32 bits.
- R5: The wide grant is refused when `ad[2]` is 1 in the address phase.
- R6: The wide grant is refused when `region_wide` is low.
- R7: Once `devsel_n` is low, `ack64_n` keeps its value until the transaction ends. This holds through wait states and whatever `req64_n` does.
- R8: A data phase completes on a clock with `irdy_n` low and either `trdy_n` or `stop_n` low. When it completes with `frame_n` high, `devsel_n` and `ack64_n` both return high at that edge.
- R9: `beat_lo` pulses for one cycle after each completed phase that had `trdy_n` low. `beat_hi` pulses with it only in a wide transaction.
- R10: `xact_end` pulses for one cycle when the transaction ends. `term` then reads 01 for a normal completion, 10 for a retry (`stop_n` low, `trdy_n` high) and 11 for a disconnect (both low).
- R11: Each transaction is negotiated afresh. A 32-bit transaction that immediately follows a wide one gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low transaction frame from the master |
| irdy_n | input | 1 | Active-low master ready |
| req64_n | input | 1 | Active-low wide data path request |
| cmd | input | 4 | Bus command code, valid in the address phase |
| ad | input | ADDR_W | Start address, valid in the address phase |
| claim_req | input | 1 | Target logic wishes to claim a decoded hit |
| region_wide | input | 1 | Decoded region supports 64-bit access |
| trdy_n | input | 1 | Active-low target ready from the target logic |
| stop_n | input | 1 | Active-low stop from the target logic |
| devsel_n | output | 1 | Active-low device select |
| ack64_n | output | 1 | Active-low wide data path acknowledge |
| beat_lo | output | 1 | Pulse: a data phase moved the low lanes |
| beat_hi | output | 1 | Pulse: a data phase moved the upper lanes |
| xact_end | output | 1 | Pulse: the claimed transaction ended |
| term | output | 2 | Termination kind, valid with `xact_end` |

## Verification
The bench builds the block with a 32-bit address, a base of 0x4000_0000 and a 1 MiB region. The hit decode can then be probed at its edges: one quadword below the region's top, exactly at the top, and below the base. The finite region also lets the wide-capable flag, the command code and address bit 2 each be varied on their own while every other grant condition is held true.

// File: rtl/wide_neg_pkg.sv
package wide_neg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } neg_state_e;

  typedef enum logic [1:0] {
    TERM_NONE  = 2'b00,
    TERM_DONE  = 2'b01,
    TERM_RETRY = 2'b10,
    TERM_DISC  = 2'b11
  } term_e;

  function automatic logic cmd_is_mem(input logic [3:0] c);
    case (c)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: cmd_is_mem = 1'b1;
      default:                                      cmd_is_mem = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wn_decode.sv
module wn_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES = 'h0010_0000
) (
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] ad,
  input  logic              req64_n,
  input  logic              claim_req,
  input  logic              region_wide,
  output logic              claim,
  output logic              wide
);
  import wide_neg_pkg::*;

  localparam logic [ADDR_W:0] LO_BOUND = {1'b0, BASE_ADDR};
  localparam logic [ADDR_W:0] HI_BOUND = {1'b0, BASE_ADDR} + {1'b0, REGION_BYTES};

  logic [ADDR_W:0] ad_ext;
  logic            in_range;
  logic            qword_ok;

  always_comb begin
    ad_ext   = {1'b0, ad};
    in_range = (ad_ext >= LO_BOUND) && (ad_ext < HI_BOUND);
    qword_ok = ~ad[2];
    claim    = claim_req & in_range;
    wide     = claim & ~req64_n & cmd_is_mem(cmd) & qword_ok & region_wide;
  end

endmodule

// File: rtl/wn_track.sv
module wn_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic       req64_n,
  input  logic       claim,
  input  logic       wide,
  output logic       devsel_n,
  output logic       ack64_n,
  output logic       req64_seen,
  output logic       beat_lo,
  output logic       beat_hi,
  output logic       xact_end,
  output logic [1:0] term
);
  import wide_neg_pkg::*;

  neg_state_e st;
  term_e      term_q;
  logic       phase_done;
  logic       bus_idle;
  term_e      term_now;

  always_comb begin
    phase_done = ~irdy_n & (~trdy_n | ~stop_n);
    bus_idle   = frame_n & irdy_n;
    if (!stop_n && trdy_n)       term_now = TERM_RETRY;
    else if (!stop_n && !trdy_n) term_now = TERM_DISC;
    else                         term_now = TERM_DONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      devsel_n   <= 1'b1;
      ack64_n    <= 1'b1;
      req64_seen <= 1'b0;
      beat_lo    <= 1'b0;
      beat_hi    <= 1'b0;
      xact_end   <= 1'b0;
      term_q     <= TERM_NONE;
    end else begin
      beat_lo  <= 1'b0;
      beat_hi  <= 1'b0;
      xact_end <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (!frame_n) begin
            req64_seen <= ~req64_n;
            if (claim) begin
              devsel_n <= 1'b0;
              ack64_n  <= ~wide;
              st       <= ST_DATA;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (phase_done) begin
            beat_lo <= ~trdy_n;
            beat_hi <= ~trdy_n & ~ack64_n;
            if (frame_n) begin
              devsel_n   <= 1'b1;
              ack64_n    <= 1'b1;
              req64_seen <= 1'b0;
              xact_end   <= 1'b1;
              term_q     <= term_now;
              st         <= ST_IDLE;
            end
          end else if (bus_idle) begin
            devsel_n   <= 1'b1;
            ack64_n    <= 1'b1;
            req64_seen <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (bus_idle) begin
            req64_seen <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign term = term_q;

endmodule

// File: rtl/wide_neg_resp.sv
module wide_neg_resp #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h4000_0000,
  parameter logic [ADDR_W-1:0] REGION_BYTES = 'h0010_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              req64_n,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] ad,
  input  logic              claim_req,
  input  logic              region_wide,
  input  logic              trdy_n,
  input  logic              stop_n,
  output logic              devsel_n,
  output logic              ack64_n,
  output logic              beat_lo,
  output logic              beat_hi,
  output logic              xact_end,
  output logic [1:0]        term
);

  logic claim;
  logic wide;
  logic req64_seen;

  wn_decode #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .REGION_BYTES(REGION_BYTES)
  ) u_decode (
    .cmd(cmd),
    .ad(ad),
    .req64_n(req64_n),
    .claim_req(claim_req),
    .region_wide(region_wide),
    .claim(claim),
    .wide(wide)
  );

  wn_track u_track (
    .clk(clk),
    .rst(rst),
    .frame_n(frame_n),
    .irdy_n(irdy_n),
    .trdy_n(trdy_n),
    .stop_n(stop_n),
    .req64_n(req64_n),
    .claim(claim),
    .wide(wide),
    .devsel_n(devsel_n),
    .ack64_n(ack64_n),
    .req64_seen(req64_seen),
    .beat_lo(beat_lo),
    .beat_hi(beat_hi),
    .xact_end(xact_end),
    .term(term)
  );

endmodule

// File: rtl/wide_neg_chk.sv
module wide_neg_chk (
  input logic       clk,
  input logic       rst,
  input logic       devsel_n,
  input logic       ack64_n,
  input logic       req64_seen,
  input logic       beat_lo,
  input logic       beat_hi,
  input logic       xact_end,
  input logic [1:0] term
);

  // R3
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !ack64_n |-> req64_seen);

  // R3
  ack_with_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    !ack64_n |-> !devsel_n);

  // R3
  ack_rise_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack64_n) |-> $fell(devsel_n));

  // R7
  ack_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && $past(!devsel_n)) |-> $stable(ack64_n));

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_n) |-> ack64_n);

  // R9
  hi_beat_chk: assert property (@(posedge clk) disable iff (rst)
    beat_hi |-> beat_lo);

  // R10
  end_term_chk: assert property (@(posedge clk) disable iff (rst)
    xact_end |-> (term != 2'b00) && devsel_n);

endmodule

bind wide_neg_resp wide_neg_chk u_chk (
  .clk(clk),
  .rst(rst),
  .devsel_n(devsel_n),
  .ack64_n(ack64_n),
  .req64_seen(req64_seen),
  .beat_lo(beat_lo),
  .beat_hi(beat_hi),
  .xact_end(xact_end),
  .term(term)
);

// File: tb/wide_neg_resp_test.sv
module wide_neg_resp_test;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] SPAN = 32'h0010_0000;
  localparam logic [3:0] C_MRD = 4'b0110, C_MWR = 4'b0111, C_IORD = 4'b0010,
                         C_CFGW = 4'b1011, C_IACK = 4'b0000, C_MRL = 4'b1110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, req64_n = 1'b1;
  logic [3:0] cmd = 4'h0;
  logic [31:0] ad = 32'h0;
  logic claim_req = 1'b0, region_wide = 1'b1;
  logic trdy_n = 1'b1, stop_n = 1'b1;
  logic devsel_n, ack64_n, beat_lo, beat_hi, xact_end;
  logic [1:0] term;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wide_neg_resp #(.ADDR_W(32), .BASE_ADDR(BASE), .REGION_BYTES(SPAN)) uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .req64_n(req64_n),
    .cmd(cmd), .ad(ad), .claim_req(claim_req), .region_wide(region_wide),
    .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ack64_n(ack64_n),
    .beat_lo(beat_lo), .beat_hi(beat_hi), .xact_end(xact_end), .term(term)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_ph(input logic [3:0] c, input logic [31:0] a, input bit r64, input bit cl);
    frame_n = 1'b0; cmd = c; ad = a; req64_n = ~r64; claim_req = cl; irdy_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic dphase(input bit last, input bit t, input bit s);
    frame_n = last; if (last) req64_n = 1'b1;
    irdy_n = 1'b0; trdy_n = ~t; stop_n = ~s;
    @(posedge clk); @(negedge clk);
    if (last && (t || s)) begin irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; end
  endtask

  task automatic go_idle();
    frame_n = 1'b1; irdy_n = 1'b1; req64_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  // Full 32-bit transaction from a given address phase; checks no wide grant.
  task automatic narrow_case(input logic [3:0] c, input logic [31:0] a, input string req);
    addr_ph(c, a, 1'b1, 1'b1);
    chk(devsel_n, 0, req);
    chk(ack64_n, 1, req);
    dphase(1'b1, 1'b1, 1'b0);
    chk(beat_lo, 1, req);
    chk(beat_hi, 0, req);
    go_idle();
  endtask

  task automatic t_reset();
    chk(devsel_n, 1, "R1 devsel");
    chk(ack64_n, 1, "R1 ack64");
    chk({beat_lo, beat_hi, xact_end}, 0, "R1 pulses");
  endtask

  task automatic t_wide_burst();
    addr_ph(C_MRD, BASE + 32'h100, 1'b1, 1'b1);
    chk(devsel_n, 0, "R2 claim");
    chk(ack64_n, 0, "R3 wide grant");
    dphase(1'b0, 1'b1, 1'b0);
    chk(beat_lo, 1, "R9 lo beat 1");
    chk(beat_hi, 1, "R9 hi beat 1");
    req64_n = 1'b1;
    dphase(1'b0, 1'b0, 1'b0);
    chk(ack64_n, 0, "R7 held through wait");
    chk(beat_lo, 0, "R9 no beat on wait");
    dphase(1'b1, 1'b1, 1'b0);
    chk(beat_hi, 1, "R9 hi beat last");
    chk(devsel_n, 1, "R8 devsel release");
    chk(ack64_n, 1, "R8 ack release");
    chk(xact_end, 1, "R10 end pulse");
    chk(term, 2'b01, "R10 normal");
    go_idle();
    chk(xact_end, 0, "R10 single pulse");
  endtask

  task automatic t_no_req();
    addr_ph(C_MWR, BASE + 32'h8, 1'b0, 1'b1);
    chk(devsel_n, 0, "R3 claim no req");
    chk(ack64_n, 1, "R3 no req no ack");
    dphase(1'b1, 1'b1, 1'b0);
    chk(beat_hi, 0, "R9 narrow no hi");
    go_idle();
  endtask

  task automatic t_commands();
    narrow_case(C_IORD, BASE + 32'h10, "R4 io");
    narrow_case(C_CFGW, BASE + 32'h10, "R4 config");
    narrow_case(C_IACK, BASE + 32'h10, "R4 int ack");
    addr_ph(C_MRL, BASE + 32'h10, 1'b1, 1'b1);
    chk(ack64_n, 0, "R4 mem read line grant");
    dphase(1'b1, 1'b1, 1'b0);
    go_idle();
  endtask

  task automatic t_misalign();
    narrow_case(C_MRD, BASE + 32'h4, "R5 odd dword");
  endtask

  task automatic t_region();
    region_wide = 1'b0;
    narrow_case(C_MRD, BASE + 32'h20, "R6 narrow region");
    region_wide = 1'b1;
  endtask

  task automatic t_decode();
    addr_ph(C_MRD, BASE + SPAN, 1'b1, 1'b1);
    chk(devsel_n, 1, "R2 top edge miss");
    chk(ack64_n, 1, "R2 miss no ack");
    go_idle();
    addr_ph(C_MRD, BASE - 32'h8, 1'b1, 1'b1);
    chk(devsel_n, 1, "R2 below base miss");
    go_idle();
    addr_ph(C_MRD, BASE + 32'h10, 1'b1, 1'b0);
    chk(devsel_n, 1, "R2 no claim request");
    go_idle();
    addr_ph(C_MRD, BASE + SPAN - 32'h8, 1'b1, 1'b1);
    chk(devsel_n, 0, "R2 last quadword hit");
    chk(ack64_n, 0, "R3 last quadword wide");
    dphase(1'b1, 1'b1, 1'b0);
    go_idle();
  endtask

  task automatic t_retry();
    addr_ph(C_MRD, BASE + 32'h40, 1'b1, 1'b1);
    dphase(1'b1, 1'b0, 1'b1);
    chk(beat_lo, 0, "R9 retry no beat");
    chk(xact_end, 1, "R10 retry end");
    chk(term, 2'b10, "R10 retry code");
    chk(ack64_n, 1, "R8 retry release");
    go_idle();
  endtask

  task automatic t_disc();
    addr_ph(C_MWR, BASE + 32'h40, 1'b1, 1'b1);
    dphase(1'b1, 1'b1, 1'b1);
    chk(beat_lo, 1, "R9 disconnect beat");
    chk(term, 2'b11, "R10 disconnect code");
    go_idle();
  endtask

  task automatic t_back_to_back();
    addr_ph(C_MRD, BASE + 32'h80, 1'b1, 1'b1);
    chk(ack64_n, 0, "R11 first wide");
    dphase(1'b1, 1'b1, 1'b0);
    addr_ph(C_MRD, BASE + 32'h88, 1'b0, 1'b1);
    chk(devsel_n, 0, "R11 second claim");
    chk(ack64_n, 1, "R11 second narrow");
    dphase(1'b1, 1'b1, 1'b0);
    chk(beat_hi, 0, "R11 second no hi");
    go_idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wide_burst();
    t_no_req();
    t_commands();
    t_misalign();
    t_region();
    t_decode();
    t_retry();
    t_disc();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule